// File: doc/BRIEF.md
# Programmable baud rate generator

This block turns a source clock into a bit-rate clock for one serial channel. Software loads a 16-bit time constant TC as two byte writes. When the block is running, a down-counter spans TC+2 source ticks and is then reloaded. Each time the count runs out, the generator output flips. One output period is therefore 2·(TC+2) source ticks, and the bit rate is f/(2·(TC+2)). A driver picks TC as ((f + bps) / (2·bps)) − 2 in integer arithmetic, which rounds to the nearest rate.

The source tick is either every cycle of the core clock or each rising edge of an external clock pin. The pin passes through a synchronizer before its edges are detected. Behind the generator sits a prescaler that divides by 1, 16, 32 or 64. It produces the one-cycle sample tick used by the serializers. Every expiry of the counter also produces a one-cycle zero-count event. That event can be read as a status bit and can raise an interrupt. Configuration uses a small register port with 4-bit indices. Reads are combinational.

Top module: `brg_top`

## Requirements
- R1: The TC low byte is written and read at index 12. The high byte is written and read at index 13. A read of index 0 returns the zero-count event in bit 1 and zeros elsewhere. Every other index reads as zero.
- R2: With the core clock as source, `gen_clk` toggles every TC+2 cycles, so its period is 2·(TC+2) cycles (4 cycles for TC=0). While stopped, `gen_clk` is low.
- R3: Index 14 bit 0 starts the countdown. Index 14 bit 1 set selects the core clock, and clear selects the external pin. An external rising edge causes a tick two cycles after the edge is sampled.
- R4: A TC written while stopped is used from the enable onwards, so the first rise comes TC+2 ticks after the enable. A TC written while running takes effect at the next reload.
- R5: `zero_evt` is high for exactly the cycle in which the count expires. It is never high two cycles in a row and is not held.
- R6: `zc_irq` mirrors `zero_evt` when index 15 bit 1 is set, and stays low otherwise.
- R7: Index 4 bits 7:6 select the prescale: 00=1, 01=16, 10=32, 11=64. `ser_tick` pulses on one rising edge of `gen_clk` out of every N, and the prescaler restarts whenever the generator is stopped.
- R8: `half_stop_ok` is low when prescale code 00 is selected, because 1.5 stop bits are not allowed at x1. It is high for the other codes.
- R9: After reset, all registers are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_idx | input | 4 | register index for the write |
| wr_data | input | 8 | write data |
| rd_idx | input | 4 | register index for the read |
| rd_data | output | 8 | read data (combinational) |
| ext_clk | input | 1 | external source clock pin |
| gen_clk | output | 1 | generator output clock |
| ser_tick | output | 1 | prescaled one-cycle sample tick |
| zero_evt | output | 1 | one-cycle counter-expiry event |
| zc_irq | output | 1 | zero-count interrupt request |
| half_stop_ok | output | 1 | 1.5 stop bits allowed with the current prescale |

## Verification
The bench builds the block with its defaults: a 16-bit time constant and a two-stage synchronizer. This lets it check the high-byte read path across all eight bits and the exact two-cycle latency of external edges. Small TC values, including TC=0, keep the x16 and x64 prescale intervals short. A cycle-accurate behavioural model then covers every reload, including a TC rewrite in the middle of a countdown.

// File: rtl/brg_pkg.sv
package brg_pkg;

   localparam logic [3:0] IDX_STAT = 4'd0;
   localparam logic [3:0] IDX_MODE = 4'd4;
   localparam logic [3:0] IDX_TCL  = 4'd12;
   localparam logic [3:0] IDX_TCH  = 4'd13;
   localparam logic [3:0] IDX_CTRL = 4'd14;
   localparam logic [3:0] IDX_IEN  = 4'd15;

   typedef enum logic [1:0] {
      PS_X1  = 2'b00,
      PS_X16 = 2'b01,
      PS_X32 = 2'b10,
      PS_X64 = 2'b11
   } ps_code_e;

   typedef struct packed {
      logic     run;
      logic     core_src;
      ps_code_e ps;
      logic     zc_ie;
   } brg_cfg_t;

   function automatic logic [6:0] ps_ratio(ps_code_e c);
      case (c)
         PS_X16:  return 7'd16;
         PS_X32:  return 7'd32;
         PS_X64:  return 7'd64;
         default: return 7'd1;
      endcase
   endfunction

endpackage

// File: rtl/brg_regs.sv
module brg_regs
   import brg_pkg::*;
#(
   parameter int unsigned TC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [3:0]      wr_idx,
   input  logic [7:0]      wr_data,
   input  logic [3:0]      rd_idx,
   input  logic            zero_evt,
   output logic [7:0]      rd_data,
   output logic [TC_W-1:0] tc,
   output brg_cfg_t        cfg
);
   localparam int unsigned HI_W = TC_W - 8;

   logic [7:0]      tc_lo_q;
   logic [HI_W-1:0] tc_hi_q;
   ps_code_e        ps_q;
   logic [1:0]      ctrl_q;
   logic            ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_lo_q <= '0;
         tc_hi_q <= '0;
         ps_q    <= PS_X1;
         ctrl_q  <= '0;
         ien_q   <= 1'b0;
      end else if (wr_en) begin
         case (wr_idx)
            IDX_TCL:  tc_lo_q <= wr_data;
            IDX_TCH:  tc_hi_q <= wr_data[HI_W-1:0];
            IDX_MODE: ps_q    <= ps_code_e'(wr_data[7:6]);
            IDX_CTRL: ctrl_q  <= wr_data[1:0];
            IDX_IEN:  ien_q   <= wr_data[1];
            default:  ;
         endcase
      end
   end

   assign tc           = {tc_hi_q, tc_lo_q};
   assign cfg.run      = ctrl_q[0];
   assign cfg.core_src = ctrl_q[1];
   assign cfg.ps       = ps_q;
   assign cfg.zc_ie    = ien_q;

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         IDX_STAT: rd_data[1]        = zero_evt;
         IDX_TCL:  rd_data           = tc_lo_q;
         IDX_TCH:  rd_data[HI_W-1:0] = tc_hi_q;
         default:  ;
      endcase
   end

endmodule

// File: rtl/brg_src_sel.sv
module brg_src_sel #(
   parameter int unsigned SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_src,
   input  logic ext_pin,
   output logic src_tick
);
   logic samp;
   logic prev_q;

   generate
      if (SYNC_N == 0) begin : g_nosync
         assign samp = ext_pin;
      end else begin : g_sync
         logic [SYNC_N-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= ext_pin;
               for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign samp = sync_q[SYNC_N-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= samp;
   end

   assign src_tick = core_src | (samp & ~prev_q);

endmodule

// File: rtl/brg_counter.sv
module brg_counter #(
   parameter int unsigned TC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            tick,
   input  logic [TC_W-1:0] tc,
   output logic            gen_clk,
   output logic            zero_evt
);
   localparam int unsigned CNT_W = TC_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;
   logic             out_q;

   assign reload   = {1'b0, tc} + {{TC_W{1'b0}}, 1'b1};
   assign zero_evt = run & tick & (cnt_q == '0);
   assign gen_clk  = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= reload;
         out_q <= 1'b0;
      end else if (tick) begin
         if (cnt_q == '0) begin
            cnt_q <= reload;
            out_q <= ~out_q;
         end else begin
            cnt_q <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
         end
      end
   end

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale
   import brg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     zero_evt,
   input  logic     gen_clk,
   input  ps_code_e ps,
   output logic     ser_tick
);
   logic [5:0] pc_q;
   logic [6:0] last;
   logic       rise;
   logic       wrap;

   assign last     = ps_ratio(ps) - 7'd1;
   assign rise     = zero_evt & ~gen_clk;
   assign wrap     = ({1'b0, pc_q} == last);
   assign ser_tick = run & rise & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q <= '0;
      else if (!run)     pc_q <= '0;
      else if (rise) begin
         if (wrap) pc_q <= '0;
         else      pc_q <= pc_q + 6'd1;
      end
   end

endmodule

// File: rtl/brg_top.sv
module brg_top
   import brg_pkg::*;
#(
   parameter int unsigned TC_W   = 16,
   parameter int unsigned SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [3:0] wr_idx,
   input  logic [7:0] wr_data,
   input  logic [3:0] rd_idx,
   output logic [7:0] rd_data,
   input  logic       ext_clk,
   output logic       gen_clk,
   output logic       ser_tick,
   output logic       zero_evt,
   output logic       zc_irq,
   output logic       half_stop_ok
);
   generate
      if (TC_W < 9 || TC_W > 16) begin : g_bad_tcw
         $error("brg_top: TC_W must lie in 9..16");
      end
      if (SYNC_N > 4) begin : g_bad_sync
         $error("brg_top: SYNC_N must not exceed 4");
      end
   endgenerate

   brg_cfg_t        cfg;
   logic [TC_W-1:0] tc;
   logic            src_tick;
   logic            run_en;

   assign run_en = cfg.run;

   brg_regs #(.TC_W(TC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .zero_evt(zero_evt),
      .rd_data(rd_data), .tc(tc), .cfg(cfg)
   );

   brg_src_sel #(.SYNC_N(SYNC_N)) u_src (
      .clk(clk), .rst_n(rst_n), .core_src(cfg.core_src),
      .ext_pin(ext_clk), .src_tick(src_tick)
   );

   brg_counter #(.TC_W(TC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_en), .tick(src_tick),
      .tc(tc), .gen_clk(gen_clk), .zero_evt(zero_evt)
   );

   brg_prescale u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_en), .zero_evt(zero_evt),
      .gen_clk(gen_clk), .ps(cfg.ps), .ser_tick(ser_tick)
   );

   assign zc_irq       = zero_evt & cfg.zc_ie;
   assign half_stop_ok = (cfg.ps != PS_X1);

endmodule

// File: rtl/brg_chk.sv
module brg_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic gen_clk,
   input logic zero_evt,
   input logic ser_tick,
   input logic zc_irq
);
   AST_RISE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_clk) |-> $past(zero_evt));                                  // R2
   AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gen_clk) |-> ($past(zero_evt) || !$past(run)));                 // R2
   AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !gen_clk);                                                   // R2
   AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> !zero_evt);                                              // R5
   AST_SER_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ser_tick |=> $rose(gen_clk));                                         // R7
   AST_IRQ_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      zc_irq |=> (gen_clk != $past(gen_clk)));                              // R6
endmodule

bind brg_top brg_chk u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_en), .gen_clk(gen_clk),
   .zero_evt(zero_evt), .ser_tick(ser_tick), .zc_irq(zc_irq)
);

// File: tb/sim_brg_top.sv
`timescale 1ns/1ps
module sim_brg_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_idx = '0;
   logic [7:0] rd_data;
   logic       ext_clk = 1'b0;
   logic       gen_clk, ser_tick, zero_evt, zc_irq, half_stop_ok;

   int  n_chk = 0;
   int  n_err = 0;
   bit  ext_on = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   brg_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .ext_clk(ext_clk), .gen_clk(gen_clk), .ser_tick(ser_tick),
      .zero_evt(zero_evt), .zc_irq(zc_irq), .half_stop_ok(half_stop_ok)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_tc, m_cnt, m_pc, m_ps;
   bit m_run, m_core, m_ie, m_out, m_s1, m_s2, m_s3;

   function automatic int ratio(int code);
      return (code == 0) ? 1 : (16 << (code - 1));
   endfunction

   function automatic bit e_tick();
      return m_core || (m_s2 && !m_s3);
   endfunction
   function automatic bit e_zero();
      return m_run && e_tick() && (m_cnt == 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tc = 0; m_cnt = 0; m_pc = 0; m_ps = 0;
         m_run = 0; m_core = 0; m_ie = 0; m_out = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         bit z, tk;
         z  = e_zero();
         tk = e_tick();
         if (!m_run) begin
            m_pc = 0;
         end else if (z && !m_out) begin
            m_pc = (m_pc == ratio(m_ps) - 1) ? 0 : m_pc + 1;
         end
         if (!m_run) begin
            m_cnt = m_tc + 1; m_out = 0;
         end else if (tk) begin
            if (m_cnt == 0) begin m_cnt = m_tc + 1; m_out = !m_out; end
            else m_cnt = m_cnt - 1;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
         if (wr_en) begin
            case (wr_idx)
               4'd12: m_tc = (m_tc & 32'hFF00) | int'(wr_data);
               4'd13: m_tc = (m_tc & 32'h00FF) | (int'(wr_data) << 8);
               4'd4:  m_ps = int'(wr_data[7:6]);
               4'd14: begin m_run = wr_data[0]; m_core = wr_data[1]; end
               4'd15: m_ie = wr_data[1];
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit z, s;
         int er;
         z = e_zero();
         s = z && !m_out && (m_pc == ratio(m_ps) - 1);
         case (rd_idx)
            4'd0:  er = z ? 2 : 0;
            4'd12: er = m_tc & 255;
            4'd13: er = (m_tc >> 8) & 255;
            default: er = 0;
         endcase
         chk(gen_clk == m_out, "R2 gen_clk", gen_clk, m_out);
         chk(zero_evt == z, "R5 zero_evt", zero_evt, z);
         chk(ser_tick == s, "R7 ser_tick", ser_tick, s);
         chk(zc_irq == (z && m_ie), "R6 zc_irq", zc_irq, z && m_ie);
         chk(half_stop_ok == (m_ps != 0), "R8 half_stop_ok", half_stop_ok, m_ps != 0);
         chk(int'(rd_data) == er, "R1 rd_data", rd_data, er);
      end
   end

   // external source pin: rising edge every 6 cycles when enabled
   initial forever begin
      repeat (3) @(negedge clk);
      if (ext_on) ext_clk = ~ext_clk;
   end

   task automatic wr(input logic [3:0] idx, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // cycles between two successive events (gen_clk rise or ser_tick pulse)
   task automatic gap(input bit use_ser, output int g);
      bit prv, cur;
      int c;
      g = -1;
      prv = use_ser ? 1'b0 : gen_clk;
      c = 0;
      while (c < 20000) begin
         @(negedge clk);
         cur = use_ser ? ser_tick : gen_clk;
         if (cur && !prv) break;
         prv = cur; c++;
      end
      prv = cur;
      for (int k = 1; k < 20000; k++) begin
         @(negedge clk);
         cur = use_ser ? ser_tick : gen_clk;
         if (cur && (use_ser || !prv)) begin g = k; break; end
         prv = cur;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int g, c, nz, ni;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(gen_clk == 0 && ser_tick == 0 && zero_evt == 0 && zc_irq == 0 && half_stop_ok == 0,
          "R9 outputs at reset", {gen_clk, ser_tick, zero_evt, zc_irq, half_stop_ok}, 0);
      rst_n = 1'b1;
      rd_idx = 4'd12; @(negedge clk);
      chk(rd_data == 0, "R9 tc low after reset", rd_data, 0);

      // R1: readback
      wr(4'd12, 8'h5A); wr(4'd13, 8'hC3);
      rd_idx = 4'd12; @(negedge clk); chk(rd_data == 8'h5A, "R1 low byte", rd_data, 8'h5A);
      rd_idx = 4'd13; @(negedge clk); chk(rd_data == 8'hC3, "R1 high byte", rd_data, 8'hC3);
      rd_idx = 4'd14; @(negedge clk); chk(rd_data == 0, "R1 other index", rd_data, 0);
      rd_idx = 4'd0;

      // R2: core source, TC=3 -> period 10
      wr(4'd13, 8'h00); wr(4'd12, 8'h03); wr(4'd14, 8'h03);
      gap(1'b0, g); chk(g == 10, "R2 period TC=3", g, 10);
      // R4: rewrite while running, takes hold after next reload
      wr(4'd12, 8'h00);
      gap(1'b0, g); gap(1'b0, g); chk(g == 4, "R4 running rewrite TC=0", g, 4);
      // R4: written while stopped, first rise TC+2 after enable
      wr(4'd14, 8'h02);
      @(negedge clk); chk(gen_clk == 0, "R2 stopped low", gen_clk, 0);
      wr(4'd12, 8'h05); wr(4'd14, 8'h03);
      c = 0;
      while (!gen_clk && c < 100) begin @(negedge clk); c++; end
      chk(c == 7, "R4 first rise after enable", c, 7);

      // R7: prescale x16 and x64 with TC=0
      wr(4'd12, 8'h00); wr(4'd4, 8'h40);
      chk(half_stop_ok == 1, "R8 x16 allows", half_stop_ok, 1);
      gap(1'b1, g); chk(g == 64, "R7 x16 interval", g, 64);
      wr(4'd4, 8'hC0);
      gap(1'b1, g); chk(g == 256, "R7 x64 interval", g, 256);
      wr(4'd4, 8'h00);
      chk(half_stop_ok == 0, "R8 x1 forbids", half_stop_ok, 0);
      gap(1'b1, g); chk(g == 4, "R7 x1 interval", g, 4);

      // R6: interrupt gating
      nz = 0; ni = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); nz += zero_evt; ni += zc_irq; end
      chk(nz > 0 && ni == 0, "R6 irq masked", ni, 0);
      wr(4'd15, 8'h02);
      nz = 0; ni = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); nz += zero_evt; ni += zc_irq; end
      chk(ni == nz && ni > 0, "R6 irq enabled", ni, nz);
      // R5: status bit at index 0 seen as pulse
      rd_idx = 4'd0; nz = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); nz += rd_data[1]; end
      chk(nz == 10, "R5 status pulses", nz, 10);

      // R3: external source, TC=1, edge every 6 cycles -> period 36
      wr(4'd12, 8'h01); ext_on = 1'b1; wr(4'd14, 8'h01);
      gap(1'b0, g); gap(1'b0, g); chk(g == 36, "R3 external period", g, 36);
      ext_on = 1'b0;
      repeat (40) @(negedge clk);
      chk(zero_evt == 0, "R3 no ticks without edges", zero_evt, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule